// File: doc/BRIEF.md
# Pipeline Cell Index Manager

This block steers the write address of a circular sample store and protects captured cells until they are read out. A write pointer steps to a new cell on every clock, wrapping at the end of the ring. When a capture request arrives, the block looks up which cell was written a programmable number of clocks earlier. It then reserves that cell by pushing its index into a small index FIFO.

The readout side sees the oldest reserved index at the FIFO head. It pops that entry when the frame for that sample is complete, and the pop frees the cell again. While a cell is reserved the write pointer steps over it. With the FIFO full, the ring therefore offers its size minus the FIFO depth as free cells, and the largest accepted latency is kept below that figure.

The latency is loaded through a small write port. A value above the allowed maximum is refused and flagged. The sample data itself is held outside this block.

Top module: `cell_index_mgr`

## Requirements
- R1: While `rst_n` is low, `wr_cell` is 0, `fill` is 0, `empty` is 1, `full`, `cap_drop` and `lat_err` are 0, and the latency is 100 clocks.
- R2: On every clock `wr_cell` moves to the next cell in ascending ring order, wrapping from NUM_CELLS-1 to 0 and stepping over every reserved cell.
- R3: A capture request at a clock edge reserves the cell that `wr_cell` showed exactly L edges earlier, where L is the current latency. L = 0 means the cell shown at the capture edge itself. Indices leave the FIFO in arrival order, and `head_cell` shows the oldest one whenever `empty` is 0.
- R4: `fill` counts the pending indices, up to FIFO_DEPTH (32). `full` is 1 exactly when `fill` equals FIFO_DEPTH, and `empty` is 1 exactly when `fill` is 0.
- R5: A capture request made while `full` is 1 is dropped and the FIFO contents are unchanged. `cap_drop` is 1 for the single cycle after that edge, and is 0 otherwise.
- R6: `frame_done` with `empty` 0 removes the head entry and frees its cell at the same edge. `frame_done` with `empty` 1 has no effect.
- R7: A latency write (`lat_we`) with `lat_val` at most MAX_LAT (150) takes effect from the next edge and clears `lat_err`. A larger value leaves the latency unchanged and sets `lat_err`.
- R8: A capture request whose target cell is already reserved is not pushed, and it does not raise `cap_drop`.
- R9: `wr_cell` never shows a cell whose index is pending in the FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_req | input | 1 | Capture request for the cell written one latency ago |
| frame_done | input | 1 | Readout of the head sample finished; pop the head entry |
| lat_we | input | 1 | Load a new latency value |
| lat_val | input | 8 | Latency in clocks |
| wr_cell | output | 8 | Cell being written this cycle |
| head_cell | output | 8 | Oldest pending index, valid when `empty` is 0 |
| fill | output | 6 | Number of pending indices |
| full | output | 1 | FIFO holds FIFO_DEPTH indices |
| empty | output | 1 | FIFO holds no index |
| cap_drop | output | 1 | One-cycle pulse after a capture was refused because the FIFO was full |
| lat_err | output | 1 | Last latency write was out of range |

## Verification
The bench uses the default parameters: 192 cells, a 32-entry FIFO and a latency limit of 150. These sizes let a few hundred idle clocks show two pointer wraps, and 40 back-to-back captures overrun the FIFO. The limit values 150 and 151 and latency 0 are all within direct reach. A long random phase with mixed captures, pops and occasional latency writes keeps up to 32 holes moving around the ring. During that phase pointer skipping, duplicate targets and simultaneous push and pop all occur.

// File: rtl/cim_pkg.sv
package cim_pkg;

  // Step a ring index forward by one with wraparound at n.
  function automatic int ring_step(input int idx, input int n);
    return (idx + 1 >= n) ? 0 : idx + 1;
  endfunction

endpackage

// File: rtl/cim_hist_line.sv
// Delay line of recently written cell indices; tap k returns the cell
// written k clocks before the current one (tap 0 is the current cell).
module cim_hist_line #(
  parameter int CELL_W = 8,
  parameter int DEPTH  = 150,
  localparam int SEL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CELL_W-1:0] cell_in,
  input  logic [SEL_W-1:0]  tap_sel,
  output logic [CELL_W-1:0] tap_out
);

  logic [CELL_W-1:0] stage_q [DEPTH];

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_stage
      logic [CELL_W-1:0] stage_d;
      if (g == 0) begin : g_first
        always_comb stage_d = cell_in;
      end else begin : g_rest
        always_comb stage_d = stage_q[g-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= '0;
        else        stage_q[g] <= stage_d;
      end
    end
  endgenerate

  always_comb begin
    tap_out = cell_in;
    for (int k = 1; k <= DEPTH; k++) begin
      if (tap_sel == SEL_W'(k)) tap_out = stage_q[k-1];
    end
  end

endmodule

// File: rtl/cim_index_fifo.sv
// Ordered store of reserved cell indices. push and pop arrive qualified.
module cim_index_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 32,
  localparam int AW    = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  logic [W-1:0]     din,
  output logic [W-1:0]     head,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty
);

  logic [W-1:0]     mem [DEPTH];
  logic [AW-1:0]    wr_q, wr_d, rd_q, rd_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (push) wr_d = (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
    if (pop)  rd_d = (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
    case ({push, pop})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_q] <= din;
  end

  assign head  = mem[rd_q];
  assign count = cnt_q;
  assign full  = (cnt_q == CNT_W'(DEPTH));
  assign empty = (cnt_q == '0);

  // R4: occupancy never exceeds the capacity
  assert_fifo_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH));

  // R5: the qualifier upstream never lets a push reach a full store
  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (!full || pop));

  // R6: a pop never reaches an empty store
  assert_no_underflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);

endmodule

// File: rtl/cim_free_seek.sv
// Finds the first unreserved cell after cur in ascending ring order.
module cim_free_seek #(
  parameter int N = 192,
  localparam int CELL_W = $clog2(N)
) (
  input  logic [CELL_W-1:0] cur,
  input  logic [N-1:0]      busy,
  output logic [CELL_W-1:0] nxt,
  output logic              found
);

  always_comb begin
    nxt   = cur;
    found = 1'b0;
    for (int k = 1; k <= N; k++) begin
      logic [CELL_W:0] idx;
      idx = {1'b0, cur} + (CELL_W + 1)'(k);
      if (idx >= (CELL_W + 1)'(N)) idx = idx - (CELL_W + 1)'(N);
      if (!found && !busy[idx[CELL_W-1:0]]) begin
        nxt   = idx[CELL_W-1:0];
        found = 1'b1;
      end
    end
  end

endmodule

// File: rtl/cell_index_mgr.sv
module cell_index_mgr #(
  parameter int NUM_CELLS  = 192,
  parameter int FIFO_DEPTH = 32,
  parameter int MAX_LAT    = 150,
  parameter int RESET_LAT  = 100,
  localparam int CELL_W = $clog2(NUM_CELLS),
  localparam int CNT_W  = $clog2(FIFO_DEPTH + 1),
  localparam int LAT_W  = $clog2(MAX_LAT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_req,
  input  logic              frame_done,
  input  logic              lat_we,
  input  logic [LAT_W-1:0]  lat_val,
  output logic [CELL_W-1:0] wr_cell,
  output logic [CELL_W-1:0] head_cell,
  output logic [CNT_W-1:0]  fill,
  output logic              full,
  output logic              empty,
  output logic              cap_drop,
  output logic              lat_err
);

  logic [CELL_W-1:0]    wr_ptr_q, wr_ptr_d;
  logic [NUM_CELLS-1:0] res_q, res_d;
  logic [LAT_W-1:0]     lat_q, lat_d;
  logic                 err_q, err_d;
  logic                 drop_q, drop_d;
  logic [CELL_W-1:0]    target;
  logic                 push_go, pop_go, seek_found;

  // cell written lat_q clocks ago
  cim_hist_line #(.CELL_W(CELL_W), .DEPTH(MAX_LAT)) i_hist (
    .clk(clk), .rst_n(rst_n), .cell_in(wr_ptr_q), .tap_sel(lat_q), .tap_out(target)
  );

  assign pop_go  = frame_done && !empty;
  assign push_go = cap_req && !full && !res_q[target];

  cim_index_fifo #(.W(CELL_W), .DEPTH(FIFO_DEPTH)) i_fifo (
    .clk(clk), .rst_n(rst_n), .push(push_go), .pop(pop_go), .din(target),
    .head(head_cell), .count(fill), .full(full), .empty(empty)
  );

  // reservation vector: release the head, then mark the new target
  always_comb begin
    res_d = res_q;
    if (pop_go)  res_d[head_cell] = 1'b0;
    if (push_go) res_d[target]    = 1'b1;
  end

  cim_free_seek #(.N(NUM_CELLS)) i_seek (
    .cur(wr_ptr_q), .busy(res_d), .nxt(wr_ptr_d), .found(seek_found)
  );

  always_comb begin
    lat_d  = lat_q;
    err_d  = err_q;
    drop_d = cap_req && full;
    if (lat_we) begin
      if (lat_val <= LAT_W'(MAX_LAT)) begin
        lat_d = lat_val;
        err_d = 1'b0;
      end else begin
        err_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      res_q    <= '0;
      lat_q    <= LAT_W'(RESET_LAT);
      err_q    <= 1'b0;
      drop_q   <= 1'b0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      res_q    <= res_d;
      lat_q    <= lat_d;
      err_q    <= err_d;
      drop_q   <= drop_d;
    end
  end

  assign wr_cell  = wr_ptr_q;
  assign cap_drop = drop_q;
  assign lat_err  = err_q;

  // R2: a free cell is always found for the next write
  assert_seek_found_R2: assert property (@(posedge clk) disable iff (!rst_n)
    seek_found && (wr_ptr_d != wr_ptr_q));

  // R9: the write pointer never sits on a reserved cell
  assert_skip_reserved_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !res_q[wr_ptr_q]);

  // R6: reservations and FIFO occupancy stay in step
  assert_fill_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(res_q) == int'(fill));

  // R5: a refused capture leaves the FIFO as it was and pulses cap_drop
  assert_drop_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_req && full && !frame_done) |=> ($stable(fill) && cap_drop));

  // R8: a capture aimed at a reserved cell does not grow the FIFO
  assert_dup_target_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_req && res_q[target] && !frame_done) |=> (fill == $past(fill)));

  // R7: the held latency is always in range
  assert_lat_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    lat_q <= LAT_W'(MAX_LAT));

endmodule

// File: tb/test_cell_index_mgr.sv
module test_cell_index_mgr;
  localparam int NC = 192;
  localparam int FD = 32;
  localparam int ML = 150;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cap_req = 1'b0, frame_done = 1'b0, lat_we = 1'b0;
  logic [7:0] lat_val = '0;
  logic [7:0] wr_cell, head_cell;
  logic [5:0] fill;
  logic       full, empty, cap_drop, lat_err;

  cell_index_mgr i_cell_index_mgr (
    .clk(clk), .rst_n(rst_n), .cap_req(cap_req), .frame_done(frame_done),
    .lat_we(lat_we), .lat_val(lat_val), .wr_cell(wr_cell), .head_cell(head_cell),
    .fill(fill), .full(full), .empty(empty), .cap_drop(cap_drop), .lat_err(lat_err)
  );

  always #10 clk = ~clk;

  int total = 0, bad = 0;
  bit done = 1'b0;

  // reference model state
  int m_ptr;
  bit m_res [NC];
  int m_q [$];
  int m_hist [ML+1];
  int m_lat;
  bit m_err, m_ovf;

  function automatic int seek_free(input int cur);
    for (int k = 1; k <= NC; k++) begin
      int idx = (cur + k) % NC;
      if (!m_res[idx]) return idx;
    end
    return cur;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cmp_all();
    chk("R2 wr_cell", int'(wr_cell), m_ptr);
    chk("R4 fill", int'(fill), m_q.size());
    chk("R4 full", int'(full), int'(m_q.size() == FD));
    chk("R4 empty", int'(empty), int'(m_q.size() == 0));
    if (m_q.size() > 0) chk("R3 head_cell", int'(head_cell), m_q[0]);
    chk("R5 cap_drop", int'(cap_drop), int'(m_ovf));
    chk("R7 lat_err", int'(lat_err), int'(m_err));
    if (wr_cell < NC) chk("R9 wr_cell not reserved", int'(m_res[wr_cell]), 0);
  endtask

  task automatic model_step();
    int  target = m_hist[m_lat];
    bit  is_full = (m_q.size() == FD);
    bit  push_ok = cap_req && !is_full && !m_res[target];
    bit  pop_ok  = frame_done && (m_q.size() > 0);
    m_ovf = cap_req && is_full;
    if (pop_ok) begin
      m_res[m_q[0]] = 1'b0;
      void'(m_q.pop_front());
    end
    if (push_ok) begin
      m_res[target] = 1'b1;
      m_q.push_back(target);
    end
    if (lat_we) begin
      if (int'(lat_val) <= ML) begin
        m_lat = int'(lat_val);
        m_err = 1'b0;
      end else begin
        m_err = 1'b1;
      end
    end
    for (int k = ML; k >= 1; k--) m_hist[k] = m_hist[k-1];
    m_ptr = seek_free(m_ptr);
    m_hist[0] = m_ptr;
  endtask

  // Drive one clock of stimulus at a negedge, step the model, compare at the next negedge.
  task automatic cycle(input bit c, input bit p, input bit lw, input int lv);
    cap_req = c; frame_done = p; lat_we = lw; lat_val = 8'(lv);
    model_step();
    @(negedge clk);
    cmp_all();
  endtask

  initial begin
    int keep_cell;
    bit seen;
    void'($urandom(32'd20240611));
    m_ptr = 0; m_lat = 100; m_err = 0; m_ovf = 0;
    foreach (m_res[i]) m_res[i] = 1'b0;
    foreach (m_hist[i]) m_hist[i] = 0;

    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 wr_cell in reset", int'(wr_cell), 0);
    chk("R1 fill in reset", int'(fill), 0);
    chk("R1 empty in reset", int'(empty), 1);
    chk("R1 full in reset", int'(full), 0);
    chk("R1 cap_drop in reset", int'(cap_drop), 0);
    chk("R1 lat_err in reset", int'(lat_err), 0);
    rst_n = 1'b1;

    // R2: free running with two wraps
    repeat (400) cycle(0, 0, 0, 0);

    // R7: out-of-range write refused, latency kept at 100
    cycle(0, 0, 1, 151);
    chk("R7 reject sets flag", int'(lat_err), 1);
    keep_cell = m_hist[100];
    cycle(1, 0, 0, 0);
    chk("R7 latency kept after reject", int'(head_cell), keep_cell);
    cycle(0, 0, 1, 150);
    chk("R7 limit value accepted", int'(lat_err), 0);
    cycle(0, 1, 0, 0);

    // R3: latency zero reserves the cell on show at the capture edge
    cycle(0, 0, 1, 0);
    keep_cell = int'(wr_cell);
    cycle(1, 0, 0, 0);
    chk("R3 latency zero target", int'(head_cell), keep_cell);
    for (int i = 0; i < NC + 4; i++) begin
      cycle(0, 0, 0, 0);
      total++;
      if (int'(wr_cell) == keep_cell) begin
        bad++;
        $display("FAIL R9 reserved cell written actual=%0d expected=not %0d", wr_cell, keep_cell);
      end
    end
    // R6: pop frees the cell, a further pop on empty does nothing
    cycle(0, 1, 0, 0);
    chk("R6 pop empties", int'(fill), 0);
    cycle(0, 1, 0, 0);
    chk("R6 pop on empty ignored", int'(fill), 0);
    seen = 1'b0;
    for (int i = 0; i < NC; i++) begin
      cycle(0, 0, 0, 0);
      if (int'(wr_cell) == keep_cell) seen = 1'b1;
    end
    chk("R6 released cell reused", int'(seen), 1);

    // R4 and R5: overrun the FIFO
    cycle(0, 0, 1, 20);
    for (int i = 0; i < 40; i++) begin
      cycle(1, 0, 0, 0);
      if (i == 35) chk("R5 drop pulse while full", int'(cap_drop), 1);
    end
    chk("R4 fill at capacity", int'(fill), FD);
    chk("R4 full flag", int'(full), 1);
    cycle(0, 0, 0, 0);
    chk("R5 drop pulse ends", int'(cap_drop), 0);
    cycle(1, 1, 0, 0);
    chk("R5 capture while full with pop", int'(fill), FD - 1);
    repeat (FD + 1) cycle(0, 1, 0, 0);
    chk("R4 drained", int'(empty), 1);

    // R8: same target reached twice through a latency change
    cycle(0, 0, 1, 5);
    cycle(1, 0, 1, 6);
    cycle(1, 0, 0, 0);
    chk("R8 duplicate target not pushed", int'(fill), 1);
    chk("R8 no drop pulse", int'(cap_drop), 0);
    cycle(0, 1, 0, 0);

    // random traffic
    for (int i = 0; i < 4000; i++) begin
      bit c  = ($urandom % 100) < 35;
      bit p  = ($urandom % 100) < 30;
      bit lw = ($urandom % 100) < 2;
      cycle(c, p, lw, int'($urandom % 200));
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL R2 watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule